// File: doc/BRIEF.md
# Dual Handshake Strobe Output Controller

This block drives two peripheral handshake lines. The first line serves inbound transfers. It pairs a processor read of the A data port with an active edge on interrupt input three. The second line serves outbound transfers. It pairs a processor write of the B data port with an active edge on interrupt input four. Edge detection and polarity selection sit in the interrupt logic, which hands this block a one-cycle event for each detected active edge.

Each line has its own 2-bit mode field from the control register: B-line mode in bits 7..6 and A-line mode in bits 5..4. A mode selects a full handshake, a fixed-width low pulse after the bus access, or a static level. The pulse width is the parameter `PULSE_CYC`, given in clock cycles. The default of 125 gives 1 µs at 125 MHz. Both outputs are registered.

Top module: `hs_strobe_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after reset, both lines read high and both handshake flip-flops are idle (high).
- R2: In mode 2'b00 (handshake), the line goes low one clock after its bus access is sampled, and high one clock after its edge event is sampled. If the access and the edge come in the same cycle, the edge wins and the line goes high.
- R3: In mode 2'b01 (pulse), the line is low for exactly `PULSE_CYC` cycles, starting with the clock edge that samples the access, and then returns high.
- R4: Mode 2'b10 drives the line low and mode 2'b11 drives it high, one clock after the mode is presented. Accesses and edge events have no effect in these modes.
- R5: The A line responds only to the A-port read strobe and the interrupt-three edge event. The B line responds only to the B-port write strobe and the interrupt-four edge event.
- R6: In any mode other than 2'b00, the line's handshake flip-flop returns to idle high. Re-entering mode 2'b00 therefore starts with the line high.
- R7: In pulse mode, an access that arrives during a pulse restarts the count. The line then stays low for `PULSE_CYC` cycles from that new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ca_mode | input | 2 | A-line mode (control register bits 5..4) |
| cb_mode | input | 2 | B-line mode (control register bits 7..6) |
| rd_a | input | 1 | One-cycle strobe: processor read of port A |
| wr_b | input | 1 | One-cycle strobe: processor write of port B |
| edge_i3 | input | 1 | One-cycle event: active edge detected on interrupt input three |
| edge_i4 | input | 1 | One-cycle event: active edge detected on interrupt input four |
| ca | output | 1 | A handshake line, registered |
| cb | output | 1 | B handshake line, registered |

## Verification
A handshake flip-flop left in the wrong state shows on the line in the very next cycle after the block enters mode 2'b00, because that mode drives its state directly to the output. A wrong pulse counter load or decrement shows up only when the pulse ends, `PULSE_CYC` cycles after the access. For that reason the bench counts low cycles rather than sampling a single point. A strobe routed to the wrong channel shows one clock after that strobe, as a change on the line that should have held steady.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    HS_HANDSHAKE = 2'b00,
    HS_PULSE     = 2'b01,
    HS_LOW       = 2'b10,
    HS_HIGH      = 2'b11
  } hs_mode_t;

  localparam int NUM_LINES = 2;
endpackage

// File: rtl/hs_channel.sv
module hs_channel
  import hs_pkg::*;
#(
  parameter int PULSE_CYC = 125
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       access,
  input  logic       edge_ev,
  output logic       line
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

  hs_mode_t         mode_e;
  logic             hs_q, hs_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             line_q, line_d;

  assign mode_e = hs_mode_t'(mode);

  always_comb begin
    hs_d   = 1'b1;
    cnt_d  = '0;
    line_d = 1'b1;
    unique case (mode_e)
      HS_HANDSHAKE: begin
        if (edge_ev)     hs_d = 1'b1;
        else if (access) hs_d = 1'b0;
        else             hs_d = hs_q;
        line_d = hs_d;
      end
      HS_PULSE: begin
        if (access)             cnt_d = CNT_LOAD;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        else                    cnt_d = '0;
        line_d = (cnt_d == '0);
      end
      HS_LOW:  line_d = 1'b0;
      HS_HIGH: line_d = 1'b1;
      default: line_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q   <= 1'b1;
      cnt_q  <= '0;
      line_q <= 1'b1;
    end else begin
      hs_q   <= hs_d;
      cnt_q  <= cnt_d;
      line_q <= line_d;
    end
  end

  assign line = line_q;

  AST_RESET_HIGH: assert property (@(posedge clk) rst |=> line); // R1
  AST_HS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && access && !edge_ev) |=> !line); // R2
  AST_HS_SET: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && edge_ev) |=> line); // R2
  AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && access) |=> !line); // R3
  AST_PULSE_END: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && !access && cnt_q == CNT_W'(1)) |=> line); // R3
  AST_MANUAL_LEVEL: assert property (@(posedge clk) disable iff (rst)
    mode[1] |=> (line == $past(mode[0]))); // R4
  AST_HS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b00) |=> hs_q); // R6
endmodule

// File: rtl/hs_strobe_ctrl.sv
module hs_strobe_ctrl
  import hs_pkg::*;
#(
  parameter int PULSE_CYC = 125
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ca_mode,
  input  logic [1:0] cb_mode,
  input  logic       rd_a,
  input  logic       wr_b,
  input  logic       edge_i3,
  input  logic       edge_i4,
  output logic       ca,
  output logic       cb
);
  logic [1:0]           modes [NUM_LINES];
  logic [NUM_LINES-1:0] acc;
  logic [NUM_LINES-1:0] edg;
  logic [NUM_LINES-1:0] lines;

  // R5: line 0 pairs port-A reads with I3 edges, line 1 pairs port-B writes with I4 edges
  assign modes[0] = ca_mode;
  assign modes[1] = cb_mode;
  assign acc      = {wr_b, rd_a};
  assign edg      = {edge_i4, edge_i3};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    hs_channel #(.PULSE_CYC(PULSE_CYC)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .mode    (modes[g]),
      .access  (acc[g]),
      .edge_ev (edg[g]),
      .line    (lines[g])
    );
  end

  assign ca = lines[0];
  assign cb = lines[1];
endmodule

// File: tb/hs_strobe_ctrl_test.sv
module hs_strobe_ctrl_test;
  localparam int P = 125;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] ca_mode = 2'b00, cb_mode = 2'b00;
  logic rd_a = 1'b0, wr_b = 1'b0, edge_i3 = 1'b0, edge_i4 = 1'b0;
  logic ca, cb;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  hs_strobe_ctrl #(.PULSE_CYC(P)) uut (
    .clk(clk), .rst(rst), .ca_mode(ca_mode), .cb_mode(cb_mode),
    .rd_a(rd_a), .wr_b(wr_b), .edge_i3(edge_i3), .edge_i4(edge_i4),
    .ca(ca), .cb(cb)
  );

  // {ca_mode, cb_mode, rd_a, wr_b, edge_i3, edge_i4, exp_ca, exp_cb}
  localparam logic [9:0] VEC [16] = '{
    10'b00_00_0000_11, 10'b00_00_1000_01, 10'b00_00_0000_01, 10'b00_00_0010_11,
    10'b00_00_0100_10, 10'b00_00_0001_11, 10'b00_00_1010_11, 10'b00_00_0101_11,
    10'b00_00_1100_00, 10'b00_00_0001_01, 10'b10_10_0000_00, 10'b11_11_0000_11,
    10'b11_11_1111_11, 10'b10_11_0000_01, 10'b00_00_0000_11, 10'b00_00_0010_11
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string row_req(input int i);
    if (i == 9) return "R5";
    if (i >= 10 && i <= 13) return "R4";
    if (i >= 14) return "R6";
    return "R2";
  endfunction

  task automatic clear_strobes();
    rd_a = 1'b0; wr_b = 1'b0; edge_i3 = 1'b0; edge_i4 = 1'b0;
  endtask

  task automatic count_low_a(output int n);
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      clear_strobes();
      if (ca == 1'b0) n++;
      else break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog expired: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int j;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "ca in reset", ca, 1);
    chk("R1", "cb in reset", cb, 1);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      {ca_mode, cb_mode, rd_a, wr_b, edge_i3, edge_i4} = VEC[i][9:2];
      @(posedge clk);
      #2;
      chk(row_req(i), $sformatf("row %0d ca", i), ca, VEC[i][1]);
      chk(row_req(i), $sformatf("row %0d cb", i), cb, VEC[i][0]);
    end

    // R4 / R5: pulse-mode A line ignores the I3 edge; B line ignores a port-A read
    @(negedge clk); clear_strobes(); ca_mode = 2'b01; cb_mode = 2'b01;
    @(negedge clk); edge_i3 = 1'b1;
    @(posedge clk); #2;
    chk("R5", "ca pulse mode with I3 edge", ca, 1);

    // R3: pulse width on the A line
    @(negedge clk); clear_strobes(); rd_a = 1'b1;
    count_low_a(n);
    chk("R3", "ca pulse width", n, P);
    chk("R5", "cb untouched by port-A read", cb, 1);

    // R3: pulse width on the B line
    @(negedge clk); wr_b = 1'b1;
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      clear_strobes();
      if (cb == 1'b0) n++;
      else break;
    end
    chk("R3", "cb pulse width", n, P);

    // R7: restart during a pulse, second access 50 cycles after the first
    @(negedge clk); rd_a = 1'b1;
    n = 0; j = 0;
    for (int k = 0; k < 2000; k++) begin
      @(posedge clk); #2;
      if (ca == 1'b0) n++;
      else break;
      j++;
      @(negedge clk);
      rd_a = (j == 50);
    end
    chk("R7", "ca restarted pulse length", n, 50 + P);

    // R1: reset from a cleared handshake state
    @(negedge clk); clear_strobes(); ca_mode = 2'b00; cb_mode = 2'b00; rd_a = 1'b1; wr_b = 1'b1;
    @(posedge clk); #2;
    chk("R2", "ca cleared before reset", ca, 0);
    @(negedge clk); clear_strobes(); rst = 1'b1;
    @(posedge clk); #2;
    chk("R1", "ca after reset", ca, 1);
    chk("R1", "cb after reset", cb, 1);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    chk("R1", "ca idle after reset release", ca, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule